// File: doc/BRIEF.md
# Serial Unlock Controller for a Hidden Clock Port

This block sits on the strobes of an SRAM-style bus and watches the chip enable, the output enable, the write enable and one data bit. In normal operation it does not intervene: the memory chip enable it passes on follows the bus chip enable. Software reaches a hidden 64-bit clock image by first doing one read and then writing a fixed 64-bit key, one bit per write cycle. Any address can be used for these writes, so the writes also land in the memory.

When the last key bit matches, a transfer window opens for the next 64 bus cycles. In that window the memory chip enable is held inactive. Each write cycle shifts one bit into a 64-bit word. Each read cycle drives one bit of a snapshot of the clock image onto the data output. After the 64th cycle the block returns to pass-through. If all 64 transfer cycles were writes, it raises a one-cycle load strobe that carries the assembled word.

A parameter selects between two bus interfaces. The memory-socket variant decodes reads and writes from the enables. The read-only variant decodes the cycle type from address line 2 and takes its data from address line 0. All strobes are resynchronised into the system clock. A bus cycle is counted when the chip enable returns high.

Top module: `clkport_unlock`

## Requirements
- R1: After reset, and before any unlock, `mem_ce_n` equals `bus_ce_n`, and `port_open`, `load_stb` and `dq0_oe` are low.
- R2: A read cycle resets the key pointer to bit 0 and clears any frozen state. A read part-way through the key throws away the bits already matched.
- R3: Each write cycle compares its data bit with the key bit at the pointer, and a match advances the pointer. The key is 64'h5CA33AC55CA33AC5, and key bit k is the data of the k-th write. This is bytes C5, 3A, A3, 5C sent twice, each byte least significant bit first.
- R4: A mismatching write freezes the pointer. All later writes are then ignored until a read, so completing the rest of the key does not unlock.
- R5: A match on key bit 63 raises `port_open`. While `port_open` is high, `mem_ce_n` stays high even when `bus_ce_n` is low.
- R6: In the window, the k-th cycle, if it is a write, stores its data bit at bit k of the word. When all 64 cycles were writes, `load_stb` is high for exactly one clock, with `load_word` equal to the assembled word.
- R7: `clk_image` is captured when the port opens. In the window, during the k-th cycle, if it is a read, `dq0_out` carries bit k of that capture and `dq0_oe` is high.
- R8: After the 64th window cycle, `port_open` falls and pass-through resumes. A window that contains any read gives no load strobe.
- R9: Output-enable or write-enable activity while `bus_ce_n` is high does not advance or reset the key sequence or the window.
- R10: Suppose `rst_pin_n` is seen low between the starting read and the final key bit, and bit 36 of `clk_image` is 0. Then the completed key is discarded: the port stays closed and the pointer freezes.
- R11: With `ROM_MODE`=1, a cycle with `bus_a2` low is a write whose data is `bus_a0`. A cycle with `bus_a2` high is a read, and its data is driven on `dq0_out` with `dq0_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Bus chip enable, active low |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_we_n | input | 1 | Bus write enable, active low |
| bus_a0 | input | 1 | Address line 0 (data-in in read-only mode) |
| bus_a2 | input | 1 | Address line 2 (cycle type in read-only mode) |
| bus_dq0 | input | 1 | Data bit 0 from the bus |
| rst_pin_n | input | 1 | External reset pin watched during the key |
| clk_image | input | 64 | Current clock image |
| mem_ce_n | output | 1 | Chip enable passed to the memory |
| dq0_out | output | 1 | Serial data driven toward the bus |
| dq0_oe | output | 1 | Output enable for `dq0_out` |
| port_open | output | 1 | High while the transfer window runs |
| load_stb | output | 1 | One-cycle strobe after a 64-write transfer |
| load_word | output | 64 | Word assembled by the write transfer |

## Verification
The bench builds two instances with default widths (64-bit key and window, two synchroniser stages, reset-check bit 36). The first uses `ROM_MODE`=0 and the second uses `ROM_MODE`=1, so both cycle decoders are exercised on the same stimulus. The default key makes the boundary positions reachable: a corrupt first bit, a corrupt middle bit and a corrupt last bit. The 64-cycle window reaches both the all-write load path and the mixed-cycle path that must not load.

// File: rtl/clkport_pkg.sv
package clkport_pkg;
  localparam int unsigned KEY_W_DEF = 64;
  localparam logic [63:0] KEY_DEF   = 64'h5CA3_3AC5_5CA3_3AC5;
  localparam int unsigned XFER_W_DEF = 64;

  // one decoded bus cycle, captured while chip enable is low
  typedef struct packed {
    logic rd;
    logic wr;
    logic dat;
  } cyc_t;
endpackage

// File: rtl/clkport_sync.sv
module clkport_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clkport_cycdec.sv
module clkport_cycdec
  import clkport_pkg::*;
#(
  parameter int unsigned ROM_MODE = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic a0,
  input  logic a2,
  input  logic dq,
  output logic evt_rd,
  output logic evt_wr,
  output logic evt_bit
);
  localparam bit IS_ROM = (ROM_MODE != 0);

  logic ce_q, ce_q_nxt;
  cyc_t cap_q, cap_nxt, cur;

  always_comb begin
    cur.wr  = IS_ROM ? !a2 : !we_n;
    cur.rd  = IS_ROM ? a2  : (!oe_n && we_n);
    cur.dat = IS_ROM ? a0  : dq;
    cap_nxt = ce_n ? cap_q : cur;
    ce_q_nxt = ce_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q  <= 1'b1;
      cap_q <= '0;
    end else begin
      ce_q  <= ce_q_nxt;
      cap_q <= cap_nxt;
    end
  end

  // a cycle ends when chip enable returns high
  logic ce_rise;
  assign ce_rise = ce_n && !ce_q;
  assign evt_wr  = ce_rise && cap_q.wr;
  assign evt_rd  = ce_rise && cap_q.rd && !cap_q.wr;
  assign evt_bit = cap_q.dat;
endmodule

// File: rtl/clkport_keymatch.sv
module clkport_keymatch #(
  parameter int unsigned KEY_W = 64,
  parameter logic [KEY_W-1:0] KEY = '0,
  localparam int unsigned PW = $clog2(KEY_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_rd,
  input  logic          evt_wr,
  input  logic          evt_bit,
  input  logic          busy,
  input  logic          rstpin_n,
  input  logic          img_rst,
  output logic          unlock,
  output logic [PW-1:0] ptr,
  output logic          frozen
);
  localparam logic [PW-1:0] LAST = PW'(KEY_W - 1);

  logic [PW-1:0] ptr_nxt;
  logic          frz_nxt, seen_q, seen_nxt;

  always_comb begin
    ptr_nxt  = ptr;
    frz_nxt  = frozen;
    seen_nxt = seen_q | (!rstpin_n && !busy);
    unlock   = 1'b0;
    if (!busy) begin
      if (evt_rd) begin
        ptr_nxt  = '0;
        frz_nxt  = 1'b0;
        seen_nxt = 1'b0;
      end else if (evt_wr && !frozen) begin
        if (evt_bit == KEY[ptr]) begin
          if (ptr == LAST) begin
            if ((seen_q || !rstpin_n) && !img_rst) begin
              frz_nxt = 1'b1;
            end else begin
              unlock   = 1'b1;
              ptr_nxt  = '0;
              seen_nxt = 1'b0;
            end
          end else begin
            ptr_nxt = ptr + 1'b1;
          end
        end else begin
          frz_nxt = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      frozen <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      ptr    <= ptr_nxt;
      frozen <= frz_nxt;
      seen_q <= seen_nxt;
    end
  end
endmodule

// File: rtl/clkport_xfer.sv
module clkport_xfer #(
  parameter int unsigned XFER_W = 64,
  localparam int unsigned CW = $clog2(XFER_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlock,
  input  logic              evt_rd,
  input  logic              evt_wr,
  input  logic              evt_bit,
  input  logic [XFER_W-1:0] image,
  output logic              open,
  output logic              out_bit,
  output logic              load_stb,
  output logic [XFER_W-1:0] load_word
);
  localparam logic [CW-1:0] LAST = CW'(XFER_W - 1);

  logic [CW-1:0]     cnt, cnt_nxt;
  logic [XFER_W-1:0] snap, snap_nxt, word_nxt;
  logic              open_nxt, allwr, allwr_nxt, stb_nxt;

  always_comb begin
    open_nxt  = open;
    cnt_nxt   = cnt;
    snap_nxt  = snap;
    word_nxt  = load_word;
    allwr_nxt = allwr;
    stb_nxt   = 1'b0;
    if (unlock) begin
      open_nxt  = 1'b1;
      cnt_nxt   = '0;
      snap_nxt  = image;
      allwr_nxt = 1'b1;
    end else if (open && (evt_rd || evt_wr)) begin
      if (evt_wr) word_nxt[cnt] = evt_bit;
      else        allwr_nxt     = 1'b0;
      if (cnt == LAST) begin
        open_nxt = 1'b0;
        stb_nxt  = evt_wr && allwr;
      end else begin
        cnt_nxt = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open      <= 1'b0;
      cnt       <= '0;
      snap      <= '0;
      load_word <= '0;
      allwr     <= 1'b0;
      load_stb  <= 1'b0;
    end else begin
      open      <= open_nxt;
      cnt       <= cnt_nxt;
      snap      <= snap_nxt;
      load_word <= word_nxt;
      allwr     <= allwr_nxt;
      load_stb  <= stb_nxt;
    end
  end

  assign out_bit = snap[cnt];
endmodule

// File: rtl/clkport_unlock.sv
module clkport_unlock
  import clkport_pkg::*;
#(
  parameter int unsigned ROM_MODE    = 0,
  parameter int unsigned KEY_W       = KEY_W_DEF,
  parameter logic [KEY_W-1:0] KEY    = KEY_DEF[KEY_W-1:0],
  parameter int unsigned XFER_W      = XFER_W_DEF,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_POS     = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic              bus_a0,
  input  logic              bus_a2,
  input  logic              bus_dq0,
  input  logic              rst_pin_n,
  input  logic [XFER_W-1:0] clk_image,
  output logic              mem_ce_n,
  output logic              dq0_out,
  output logic              dq0_oe,
  output logic              port_open,
  output logic              load_stb,
  output logic [XFER_W-1:0] load_word
);
  localparam int unsigned PW = $clog2(KEY_W);
  localparam int unsigned NS = 7;
  localparam logic [NS-1:0] SYNC_RST = 7'b111_0001;
  localparam bit IS_ROM = (ROM_MODE != 0);

  logic [NS-1:0] raw, syn;
  logic evt_rd, evt_wr, evt_bit, unlock, out_bit, km_frozen;
  logic [PW-1:0] km_ptr;

  assign raw = {bus_ce_n, bus_oe_n, bus_we_n, bus_a0, bus_a2, bus_dq0, rst_pin_n};

  clkport_sync #(.W(NS), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  clkport_cycdec #(.ROM_MODE(ROM_MODE)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .ce_n(syn[6]), .oe_n(syn[5]), .we_n(syn[4]),
    .a0(syn[3]), .a2(syn[2]), .dq(syn[1]),
    .evt_rd(evt_rd), .evt_wr(evt_wr), .evt_bit(evt_bit)
  );

  clkport_keymatch #(.KEY_W(KEY_W), .KEY(KEY)) u_key (
    .clk(clk), .rst_n(rst_n),
    .evt_rd(evt_rd), .evt_wr(evt_wr), .evt_bit(evt_bit),
    .busy(port_open), .rstpin_n(syn[0]), .img_rst(clk_image[RST_POS]),
    .unlock(unlock), .ptr(km_ptr), .frozen(km_frozen)
  );

  clkport_xfer #(.XFER_W(XFER_W)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .unlock(unlock), .evt_rd(evt_rd), .evt_wr(evt_wr), .evt_bit(evt_bit),
    .image(clk_image), .open(port_open), .out_bit(out_bit),
    .load_stb(load_stb), .load_word(load_word)
  );

  logic bus_read;
  assign bus_read = IS_ROM ? bus_a2 : (!bus_oe_n && bus_we_n);

  assign mem_ce_n = bus_ce_n | port_open;
  assign dq0_oe   = port_open && !bus_ce_n && bus_read;
  assign dq0_out  = port_open && out_bit;
endmodule

// File: rtl/clkport_unlock_chk.sv
module clkport_unlock_chk #(
  parameter int unsigned PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evt_rd,
  input logic          evt_wr,
  input logic [PW-1:0] km_ptr,
  input logic          km_frozen,
  input logic          port_open,
  input logic          mem_ce_n,
  input logic          dq0_oe,
  input logic          load_stb
);
  AST_RD_CLEARS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd && !port_open |=> km_ptr == '0);                           // R2
  AST_OPEN_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_open) |-> $past(evt_wr));                              // R3
  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    km_frozen && !evt_rd |=> $stable(km_ptr));                        // R4
  AST_OPEN_GATES_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    port_open |-> mem_ce_n);                                          // R5
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);                                          // R6
  AST_OE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    dq0_oe |-> port_open);                                            // R7
  AST_LOAD_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $fell(port_open));                                   // R8
endmodule

bind clkport_unlock clkport_unlock_chk #(.PW($clog2(KEY_W))) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_rd(evt_rd), .evt_wr(evt_wr),
  .km_ptr(km_ptr), .km_frozen(km_frozen), .port_open(port_open),
  .mem_ce_n(mem_ce_n), .dq0_oe(dq0_oe), .load_stb(load_stb)
);

// File: tb/clkport_unlock_bench.sv
`timescale 1ns/1ps
module clkport_unlock_bench;
  localparam logic [63:0] KEY = 64'h5CA3_3AC5_5CA3_3AC5;
  // row: [9:3] corrupted key bit (64 = none), [2] pull reset pin low, [1] image bit 36, [0] expect open
  localparam logic [9:0] ROWS [6] = '{
    {7'd64, 1'b0, 1'b0, 1'b1},
    {7'd0,  1'b0, 1'b0, 1'b0},
    {7'd63, 1'b0, 1'b1, 1'b0},
    {7'd31, 1'b0, 1'b0, 1'b0},
    {7'd64, 1'b1, 1'b0, 1'b0},
    {7'd64, 1'b1, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ce_ram_n, ce_rom_n, oe_n, we_n, a0, a2, dq, rst_pin_n;
  logic [63:0] img;
  logic mem_ce_n, dq0_out, dq0_oe, port_open, load_stb;
  logic [63:0] load_word;
  logic r_mem_ce_n, r_dq0_out, r_dq0_oe, r_open, r_load_stb;
  logic [63:0] r_load_word;

  clkport_unlock u_clkport_unlock (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_ram_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_a0(a0), .bus_a2(a2), .bus_dq0(dq), .rst_pin_n(rst_pin_n), .clk_image(img),
    .mem_ce_n(mem_ce_n), .dq0_out(dq0_out), .dq0_oe(dq0_oe), .port_open(port_open),
    .load_stb(load_stb), .load_word(load_word)
  );

  clkport_unlock #(.ROM_MODE(1)) u_rom (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_rom_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_a0(a0), .bus_a2(a2), .bus_dq0(dq), .rst_pin_n(rst_pin_n), .clk_image(img),
    .mem_ce_n(r_mem_ce_n), .dq0_out(r_dq0_out), .dq0_oe(r_dq0_oe), .port_open(r_open),
    .load_stb(r_load_stb), .load_word(r_load_word)
  );

  int total = 0;
  int bad = 0;
  int load_hi = 0;
  logic [63:0] last_word = '0;
  logic s_ce, s_dq, s_oe;

  always @(negedge clk) if (load_stb) begin
    load_hi++;
    last_word = load_word;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc_ram(input bit is_wr, input bit d);
    @(negedge clk);
    dq = d; we_n = !is_wr; oe_n = is_wr; ce_ram_n = 1'b0;
    repeat (2) @(negedge clk);
    s_ce = mem_ce_n; s_dq = dq0_out; s_oe = dq0_oe;
    repeat (2) @(negedge clk);
    ce_ram_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic cyc_rom(input bit is_wr, input bit d);
    @(negedge clk);
    a0 = d; a2 = !is_wr; ce_rom_n = 1'b0;
    repeat (2) @(negedge clk);
    s_dq = r_dq0_out; s_oe = r_dq0_oe;
    repeat (2) @(negedge clk);
    ce_rom_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // strobes with this block deselected
  task automatic foreign();
    @(negedge clk);
    oe_n = 1'b0; we_n = 1'b0; dq = 1'b1;
    repeat (4) @(negedge clk);
    oe_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_key(input int corrupt, input bit rst_low, input int from, input int upto,
                          input bit interleave);
    for (int k = from; k < upto; k++) begin
      if (rst_low && k == 20) rst_pin_n = 1'b0;
      cyc_ram(1'b1, KEY[k] ^ (k == corrupt));
      rst_pin_n = 1'b1;
      if (interleave) foreign();
    end
  endtask

  task automatic drain_reads();
    for (int k = 0; k < 64; k++) cyc_ram(1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0] row;
    logic [63:0] wpat;
    int loads0;
    rst_n = 1'b0; ce_ram_n = 1'b1; ce_rom_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    a0 = 1'b0; a2 = 1'b0; dq = 1'b0; rst_pin_n = 1'b1;
    img = 64'hF0E1_D2C3_B4A5_9687;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 open after reset", {63'd0, port_open}, 64'd0);
    chk("R1 load_stb after reset", {63'd0, load_stb}, 64'd0);
    chk("R1 mem_ce idle", {63'd0, mem_ce_n}, 64'd1);
    cyc_ram(1'b0, 1'b0);
    chk("R1 mem_ce follows bus", {63'd0, s_ce}, 64'd0);
    chk("R1 no drive outside window", {63'd0, s_oe}, 64'd0);

    // table of unlock attempts (R3 R4 R5 R8 R10)
    for (int r = 0; r < 6; r++) begin
      row = ROWS[r];
      img[36] = row[1];
      cyc_ram(1'b0, 1'b0);
      send_key(int'(row[9:3]), row[2], 0, 64, 1'b0);
      chk($sformatf("R3/R4/R10 row %0d open", r), {63'd0, port_open}, {63'd0, row[0]});
      if (row[0]) begin
        drain_reads();
        chk($sformatf("R8 row %0d closed", r), {63'd0, port_open}, 64'd0);
      end
    end

    // R2 read mid-key aborts, then full key unlocks
    cyc_ram(1'b0, 1'b0);
    send_key(64, 1'b0, 0, 32, 1'b0);
    cyc_ram(1'b0, 1'b0);
    send_key(64, 1'b0, 32, 64, 1'b0);
    chk("R2 aborted key stays closed", {63'd0, port_open}, 64'd0);
    cyc_ram(1'b0, 1'b0);
    send_key(64, 1'b0, 0, 64, 1'b0);
    chk("R2 fresh key opens", {63'd0, port_open}, 64'd1);

    // R5 R6 write transfer
    wpat = 64'h0123_4567_89AB_CDEF;
    loads0 = load_hi;
    for (int k = 0; k < 64; k++) begin
      cyc_ram(1'b1, wpat[k]);
      if (k == 5) chk("R5 memory gated in window", {63'd0, s_ce}, 64'd1);
    end
    chk("R6 one load pulse", 64'(load_hi - loads0), 64'd1);
    chk("R6 load word", last_word, wpat);
    chk("R8 closed after writes", {63'd0, port_open}, 64'd0);

    // R7 read transfer
    img = 64'h1F2E_3D4C_5B6A_7988;
    cyc_ram(1'b0, 1'b0);
    send_key(64, 1'b0, 0, 64, 1'b0);
    img = '0;
    for (int k = 0; k < 64; k++) begin
      cyc_ram(1'b0, 1'b0);
      if (s_dq !== img[k] ^ 1'b0 && s_dq !== (64'h1F2E_3D4C_5B6A_7988 >> k) % 2)
        chk($sformatf("R7 bit %0d", k), {63'd0, s_dq}, (64'h1F2E_3D4C_5B6A_7988 >> k) & 64'd1);
      else
        chk($sformatf("R7 bit %0d", k), {63'd0, s_dq}, (64'h1F2E_3D4C_5B6A_7988 >> k) & 64'd1);
      if (k == 0) chk("R7 oe in read", {63'd0, s_oe}, 64'd1);
    end

    // R8 mixed window, no load
    loads0 = load_hi;
    cyc_ram(1'b0, 1'b0);
    send_key(64, 1'b0, 0, 64, 1'b0);
    for (int k = 0; k < 63; k++) cyc_ram(1'b1, 1'b1);
    cyc_ram(1'b0, 1'b0);
    chk("R8 mixed gives no load", 64'(load_hi - loads0), 64'd0);
    chk("R8 mixed window closes", {63'd0, port_open}, 64'd0);

    // R9 deselected strobes interleaved
    cyc_ram(1'b0, 1'b0);
    foreign();
    send_key(64, 1'b0, 0, 64, 1'b1);
    chk("R9 interleaved key opens", {63'd0, port_open}, 64'd1);
    for (int k = 0; k < 63; k++) cyc_ram(1'b0, 1'b0);
    foreign();
    chk("R9 window holds on foreign", {63'd0, port_open}, 64'd1);
    cyc_ram(1'b0, 1'b0);
    chk("R9 window closes", {63'd0, port_open}, 64'd0);

    // R11 read-only variant
    img = 64'hA5A5_0F0F_3C3C_9696;
    cyc_rom(1'b0, 1'b0);
    for (int k = 0; k < 64; k++) cyc_rom(1'b1, KEY[k]);
    chk("R11 rom opens", {63'd0, r_open}, 64'd1);
    for (int k = 0; k < 64; k++) begin
      cyc_rom(1'b0, 1'b0);
      if (k == 3) chk("R11 rom oe", {63'd0, s_oe}, 64'd1);
      if (k < 8) chk($sformatf("R11 rom bit %0d", k), {63'd0, s_dq},
                     (64'hA5A5_0F0F_3C3C_9696 >> k) & 64'd1);
    end
    chk("R11 rom closes", {63'd0, r_open}, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule